// File: doc/BRIEF.md
# Sorted Soft-Decision Flip-Pattern Generator

This block lists bit-flip hypotheses for one half of a received block, ordered from most likely to least likely. A load pulse captures K unsigned reliability magnitudes in parallel, one per bit position. The block then streams K-bit flip patterns, each with a cost equal to the sum of the magnitudes of the positions it flips. The stream is in nondecreasing cost order and starts with the all-zero pattern. It covers the whole pattern space in true cost order, not only combinations of a few weak positions. A downstream candidate tester uses it to try the likeliest corrections first.

The generator is a chain of K processing elements. Element i receives the sorted stream of patterns over positions below i. It merges that stream with a delayed copy of itself, in which position i is flipped and magnitude i is added. Each element keeps the items it has forwarded in a small FIFO, so the copy costs no second pass over the stream. Once the chain has filled, it delivers one pattern per cycle.

The output is a valid/ready stream. When `out_valid` is high and `out_ready` is low, the pattern and cost hold unchanged until they are accepted. A transfer happens on each clock edge where both are high. The consumer may hold `out_ready` low for any number of cycles, and no pattern is lost or repeated. `load` and `stop` are plain control pins.

Top module: `sorted_flip_gen`

## Requirements
- R1: A `load` pulse captures `mag_i` and clears all internal state in that cycle, even when a previous frame is still streaming. The first pattern of each frame is all-zero with cost 0.
- R2: With `out_ready` held high, `out_valid` first rises after the K-th rising edge that follows the edge that sampled `load`.
- R3: Bit i of `out_pat` stands for position i, and its magnitude is `mag_i[i*W +: W]`. `out_cost` equals the sum of the magnitudes of the set bits of `out_pat`.
- R4: Within a frame, accepted costs never decrease. Every pattern appears at its place in that order, including patterns that flip more reliable positions than other, costlier patterns.
- R5: Patterns of equal cost come out in ascending numeric value of `out_pat`, taken as an unsigned number with bit K-1 as its MSB.
- R6: Once the first pattern is valid, `out_valid` stays high on every cycle until the frame ends, so one pattern transfers per cycle while `out_ready` is high.
- R7: Exactly RHO patterns transfer per frame. `out_last` is high with the RHO-th pattern, and `out_valid` stays low after that pattern is accepted, until the next load.
- R8: A `stop` sampled without `load` drives `out_valid` low from the next cycle until the next load. When both are sampled together, `load` wins.
- R9: While `out_valid` is high and `out_ready` is low, `out_pat`, `out_cost` and `out_last` hold steady, and no pattern is skipped or repeated.
- R10: After reset, `out_valid` stays low until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Start a frame; captures `mag_i` |
| mag_i | input | K*W | Reliability magnitudes; position i is in bits [i*W +: W] |
| stop | input | 1 | End the current frame early |
| out_valid | output | 1 | A pattern is offered |
| out_ready | input | 1 | Consumer accepts the offered pattern |
| out_pat | output | K | Flip pattern; bit i flips position i |
| out_cost | output | W+clog2(K) | Sum of the flipped magnitudes |
| out_last | output | 1 | Marks the RHO-th pattern of the frame |

## Verification
On every cycle, the assertions check that the offered cost equals the sum of the flipped magnitudes. They also check the ordering against the last accepted pattern by cost and then by value, that a stalled offer holds, that stop and the final transfer silence the output, and that no element's FIFO overflows. Other behaviour only the bench's reference model can show. That covers completeness, meaning that no cheaper pattern is ever skipped, and the exact fill latency. It also covers a reload in the middle of a frame, and the equal-cost order over all-zero and all-equal magnitude sets under random back-pressure.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  // Cost bus width: a sum of k values of w bits never overflows it.
  function automatic int cost_width(input int k, input int w);
    return w + $clog2(k);
  endfunction
endpackage

// File: rtl/pat_fifo.sv
module pat_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // A full queue would drop a pattern and break completeness.
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full && !clr));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty && !clr));
endmodule

// File: rtl/flip_pe.sv
module flip_pe #(
  parameter int K     = 12,
  parameter int CW    = 12,
  parameter int IDX   = 0,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] mag,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [K-1:0]  in_pat,
  input  logic [CW-1:0] in_cost,
  input  logic          in_inf,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [K-1:0]  out_pat,
  output logic [CW-1:0] out_cost,
  output logic          out_inf
);
  localparam int DW = K + CW;
  localparam logic [K-1:0] BIT = K'(1) << IDX;

  logic          q_push, q_pop, q_empty, q_full;
  logic [DW-1:0] q_head;
  logic [K-1:0]  h_pat;
  logic [CW-1:0] h_cost, alt_cost;
  logic [K-1:0]  alt_pat;
  logic          slot_free, fire, take_alt;

  pat_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(q_push), .push_data({in_pat, in_cost}),
    .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  assign {h_pat, h_cost} = q_head;
  assign alt_pat   = h_pat | BIT;
  assign alt_cost  = h_cost + mag;

  // The copy stream wins only when strictly cheaper: ties keep the lower top bit first.
  assign slot_free = !out_valid || out_ready;
  assign fire      = slot_free && in_valid;
  assign take_alt  = !q_empty && (in_inf || (alt_cost < in_cost));
  assign in_ready  = fire && !take_alt;
  assign q_push    = in_ready && !in_inf;
  assign q_pop     = fire && take_alt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pat   <= '0;
      out_cost  <= '0;
      out_inf   <= 1'b0;
    end else if (clr) begin
      out_valid <= 1'b0;
      out_inf   <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      if (take_alt) begin
        out_pat  <= alt_pat;
        out_cost <= alt_cost;
        out_inf  <= 1'b0;
      end else begin
        out_pat  <= in_pat;
        out_cost <= in_cost;
        out_inf  <= in_inf;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_stage_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !clr |=> out_valid && $stable(out_pat) && $stable(out_cost));
  p_stage_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_inf |-> (out_pat >> (IDX + 1)) == '0);
endmodule

// File: rtl/sorted_flip_gen.sv
module sorted_flip_gen #(
  parameter int K   = 12,
  parameter int W   = 8,
  parameter int RHO = 16,
  localparam int CW = sfg_pkg::cost_width(K, W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [K*W-1:0] mag_i,
  input  logic          stop,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [K-1:0]  out_pat,
  output logic [CW-1:0] out_cost,
  output logic          out_last
);
  localparam int DEPTH = RHO + K + 2;
  localparam int NW    = $clog2(RHO + 1);

  logic [K*W-1:0] mag_q;
  logic           active, zero_sent;
  logic [NW-1:0]  sent_cnt;
  logic           run;

  logic [K:0]          st_v, st_r, st_inf;
  logic [K:0][K-1:0]   st_pat;
  logic [K:0][CW-1:0]  st_cost;

  // Source: the empty pattern once, then an endless exhausted marker.
  assign st_v[0]    = active;
  assign st_pat[0]  = '0;
  assign st_cost[0] = '0;
  assign st_inf[0]  = zero_sent;

  generate
    for (genvar i = 0; i < K; i++) begin : g_pe
      flip_pe #(.K(K), .CW(CW), .IDX(i), .DEPTH(DEPTH)) u_pe (
        .clk(clk), .rst_n(rst_n), .clr(load),
        .mag(CW'(mag_q[i*W +: W])),
        .in_valid(st_v[i]), .in_ready(st_r[i]),
        .in_pat(st_pat[i]), .in_cost(st_cost[i]), .in_inf(st_inf[i]),
        .out_valid(st_v[i+1]), .out_ready(st_r[i+1]),
        .out_pat(st_pat[i+1]), .out_cost(st_cost[i+1]), .out_inf(st_inf[i+1])
      );
    end
  endgenerate

  assign run       = active && (sent_cnt != NW'(RHO));
  assign st_r[K]   = run && (out_ready || st_inf[K]);
  assign out_valid = run && st_v[K] && !st_inf[K];
  assign out_pat   = st_pat[K];
  assign out_cost  = st_cost[K];
  assign out_last  = (sent_cnt == NW'(RHO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q     <= '0;
      active    <= 1'b0;
      zero_sent <= 1'b0;
      sent_cnt  <= '0;
    end else if (load) begin
      mag_q     <= mag_i;
      active    <= 1'b1;
      zero_sent <= 1'b0;
      sent_cnt  <= '0;
    end else begin
      if (stop) active <= 1'b0;
      if (st_v[0] && st_r[0]) zero_sent <= 1'b1;
      if (out_valid && out_ready) sent_cnt <= sent_cnt + 1'b1;
    end
  end

  // Assertion support: last accepted pattern of the frame.
  logic          have_prev;
  logic [K-1:0]  prev_pat;
  logic [CW-1:0] prev_cost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_pat  <= '0;
      prev_cost <= '0;
    end else if (load) begin
      have_prev <= 1'b0;
    end else if (out_valid && out_ready) begin
      have_prev <= 1'b1;
      prev_pat  <= out_pat;
      prev_cost <= out_cost;
    end
  end

  function automatic logic [CW-1:0] flipped_sum(input logic [K-1:0] p, input logic [K*W-1:0] m);
    logic [CW-1:0] s;
    s = '0;
    for (int j = 0; j < K; j++) if (p[j]) s = s + CW'(m[j*W +: W]);
    return s;
  endfunction

  p_zero_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !have_prev |-> out_pat == '0 && out_cost == '0);
  p_cost_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_cost == flipped_sum(out_pat, mag_q));
  p_nondecr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && have_prev |-> out_cost >= prev_cost);
  p_tie_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && have_prev && out_cost == prev_cost |-> out_pat > prev_pat);
  p_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last && !load |=> !out_valid);
  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !load |=> !out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !stop && !load |=> out_valid && $stable(out_pat) && $stable(out_cost) && $stable(out_last));
endmodule

// File: tb/tb_sorted_flip_gen.sv
module tb_sorted_flip_gen;
  localparam int K   = 12;
  localparam int W   = 8;
  localparam int RHO = 16;
  localparam int CW  = W + $clog2(K);

  logic clk = 1'b0;
  logic rst_n, load, stop, out_ready;
  logic [K*W-1:0] mag_bus;
  logic out_valid, out_last;
  logic [K-1:0] out_pat;
  logic [CW-1:0] out_cost;

  always #10 clk = ~clk;

  sorted_flip_gen #(.K(K), .W(W), .RHO(RHO)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .mag_i(mag_bus), .stop(stop),
    .out_valid(out_valid), .out_ready(out_ready), .out_pat(out_pat),
    .out_cost(out_cost), .out_last(out_last)
  );

  int errors = 0, checks = 0;
  int mags [K];
  int exp_pat [RHO];
  int exp_cost [RHO];
  bit running = 0, stopped = 0, stalled = 0, done = 0;
  int n = 0, idx = 0;
  int rnd_ready = 0;

  function automatic int pcost(input int p);
    int s = 0;
    for (int j = 0; j < K; j++) if (p[j]) s += mags[j];
    return s;
  endfunction

  // Reference: repeatedly take the smallest (cost, value) above the previous one.
  task automatic build_list();
    int pc = -1, pp = -1;
    for (int l = 0; l < RHO; l++) begin
      int bc = 1 << 30, bp = 1 << 30;
      for (int p = 0; p < (1 << K); p++) begin
        int c = pcost(p);
        bit above = (c > pc) || (c == pc && p > pp);
        bit below = (c < bc) || (c == bc && p < bp);
        if (above && below) begin bc = c; bp = p; end
      end
      exp_pat[l] = bp; exp_cost[l] = bc; pc = bc; pp = bp;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev;
      ev = running && (n >= K) && (idx < RHO);
      checks++;
      if (out_valid !== ev) begin
        string tag;
        if (!running) tag = stopped ? "R8" : "R10";
        else if (idx >= RHO) tag = "R7";
        else if (n <= K) tag = "R2";
        else tag = "R6";
        errors++;
        $display("FAIL %s valid: actual=%0b expected=%0b (n=%0d idx=%0d)", tag, out_valid, ev, n, idx);
      end else if (ev) begin
        bit lexp;
        lexp = (idx == RHO - 1);
        checks++;
        if (int'(out_pat) != exp_pat[idx] || int'(out_cost) != exp_cost[idx]) begin
          string tag;
          if (idx == 0) tag = "R1";
          else if (stalled) tag = "R9";
          else if (int'(out_cost) != pcost(int'(out_pat))) tag = "R3";
          else if (int'(out_cost) == exp_cost[idx]) tag = "R5";
          else tag = "R4";
          errors++;
          $display("FAIL %s item %0d: actual pat=%h cost=%0d expected pat=%h cost=%0d",
                   tag, idx, out_pat, out_cost, exp_pat[idx], exp_cost[idx]);
        end else if (out_last !== lexp) begin
          errors++;
          $display("FAIL R7 last at item %0d: actual=%0b expected=%0b", idx, out_last, lexp);
        end
      end
      // Advance the model to the state after the coming edge.
      if (load) begin
        build_list();
        running = 1; stopped = 0; n = 0; idx = 0; stalled = 0;
      end else begin
        stalled = ev && !out_ready;
        if (ev && out_ready) idx++;
        if (stop && running) begin running = 0; stopped = 1; end
        if (running) n++;
      end
    end
  end

  always @(posedge clk) if (rnd_ready != 0) out_ready <= #1 (($urandom % 3) != 0);

  task automatic cycles(input int c);
    repeat (c) @(posedge clk);
  endtask

  task automatic start_frame();
    for (int j = 0; j < K; j++) mag_bus[j*W +: W] = W'(mags[j]);
    @(posedge clk); #1 load = 1;
    @(posedge clk); #1 load = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 0; load = 0; stop = 0; out_ready = 1; mag_bus = '0;
    for (int j = 0; j < K; j++) mags[j] = 0;
    cycles(3); #1 rst_n = 1;
    cycles(6);                                    // R10: idle after reset

    // R4 R3: weak-position example plus ties at 30 and 35 (R5)
    mags = '{35, 20, 10, 35, 30, 90, 100, 110, 120, 130, 140, 150};
    start_frame(); cycles(K + RHO + 6);

    // R5 R9: all equal magnitudes, random back-pressure
    for (int j = 0; j < K; j++) mags[j] = 7;
    rnd_ready = 1; start_frame(); cycles(90);
    rnd_ready = 0; #1 out_ready = 1;

    // R5: all zero costs, order by value
    for (int j = 0; j < K; j++) mags[j] = 0;
    start_frame(); cycles(K + RHO + 4);

    // R1: reload in the middle of a frame
    for (int j = 0; j < K; j++) mags[j] = $urandom % 256;
    start_frame(); cycles(K + 5);
    for (int j = 0; j < K; j++) mags[j] = $urandom % 64;
    rnd_ready = 1; start_frame(); cycles(80);
    rnd_ready = 0; #1 out_ready = 1;

    // R8: stop mid-frame, stays idle
    for (int j = 0; j < K; j++) mags[j] = 255 - 10 * j;
    start_frame(); cycles(K + 4);
    #1 stop = 1; @(posedge clk); #1 stop = 0;
    cycles(12);

    // R2 R6 R7: clean frame with maximal magnitudes
    for (int j = 0; j < K; j++) mags[j] = 255;
    start_frame(); cycles(K + RHO + 6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule